// File: doc/BRIEF.md
# Receive-Occupancy RTS Pacer

This block drives the active-low request-to-send line of a serial receiver from the receive FIFO's current fill count. A 2-bit code picks a trigger level. The receive-threshold interrupt is raised while the fill is at or above that level. When automatic pacing is on, the RTS line is released (driven high) once the fill reaches the trigger level one step above the selected one. It is asserted again (driven low) only after the fill has fallen below the level one step beneath the selected one. This gives the remote sender a hysteresis band, so the line does not toggle on every byte.

When automatic pacing is off, the line simply mirrors a software-controlled request bit. The FIFO, clear-to-send handling and the transmitter live elsewhere. The block only reads the fill count and drives two registered outputs. Both outputs change on the clock edge that follows the inputs that cause the change.

Top module: `rts_flow_ctrl`

## Requirements
- R1: While reset is held, `rts_n` is 1 and `thr_irq` is 0, whatever the other inputs are.
- R2: Trigger code 0, 1, 2 and 3 select a level of 1, DEPTH/4, DEPTH/2 and DEPTH-2 entries. With DEPTH=16 these are 1, 4, 8 and 14.
- R3: `thr_irq` is 1 in the cycle after a clock edge at which `fill` is greater than or equal to the selected level, and 0 otherwise. This holds whether or not automatic pacing is enabled.
- R4: With `auto_en`=1, `rts_n` becomes 1 after an edge at which `fill` is greater than or equal to the next higher level. For code 3 the next higher level is DEPTH, the full count.
- R5: With `auto_en`=1 and `fill` below the next higher level, `rts_n` becomes 0 after an edge at which `fill` is below the next lower level. For code 0, whose next lower level is 0, this condition is `fill`==0.
- R6: With `auto_en`=1 and `fill` between the two conditions of R4 and R5, `rts_n` keeps its previous value.
- R7: With `auto_en`=0, `rts_n` equals the inverse of `sw_rts` one cycle later, and `fill` has no effect on it.
- R8: With `auto_en`=1, `sw_rts` has no effect on `rts_n`.
- R9: A change of `trig_sel` takes effect on the next clock edge, for both the interrupt and the RTS thresholds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill | input | $clog2(DEPTH+1) | Current receive FIFO occupancy |
| trig_sel | input | 2 | Trigger level code (0..3) |
| auto_en | input | 1 | Enables automatic RTS pacing |
| sw_rts | input | 1 | Software request bit, used when pacing is off |
| rts_n | output | 1 | Active-low request-to-send line |
| thr_irq | output | 1 | Receive-threshold interrupt |

## Verification
The bench builds the block with DEPTH=16. At that depth the four levels 1, 4, 8 and 14 are distinct, and the full count of 16 can be driven, so the saturated upper bound of code 3 and the empty-only reassert of code 0 are both exercised. It ramps the fill up and down through every count for each code. It also probes the hold band, software mode, the software bit being ignored in automatic mode, and a code change made in the middle of the hysteresis band.

// File: rtl/rts_pkg.sv
package rts_pkg;

  typedef enum logic [1:0] {
    TRIG_MIN  = 2'd0,
    TRIG_QTR  = 2'd1,
    TRIG_HALF = 2'd2,
    TRIG_NEAR = 2'd3
  } trig_code_t;

  // Selected trigger level in entries (R2).
  function automatic int unsigned trig_level(input logic [1:0] code, input int unsigned depth);
    case (code)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

  // Level one step above the selected one; the top code saturates at full.
  function automatic int unsigned upper_level(input logic [1:0] code, input int unsigned depth);
    if (code == 2'd3) return depth;
    return trig_level(code + 2'd1, depth);
  endfunction

  // Level one step beneath the selected one; the bottom code bottoms at 0.
  function automatic int unsigned lower_level(input logic [1:0] code, input int unsigned depth);
    if (code == 2'd0) return 0;
    return trig_level(code - 2'd1, depth);
  endfunction

endpackage

// File: rtl/rts_level_decode.sv
module rts_level_decode
  import rts_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] fill,
  input  logic [1:0]    trig_sel,
  output logic          at_trig,
  output logic          hit_upper,
  output logic          below_lower
);

  localparam int unsigned NCODE = 4;

  logic [CW-1:0] lvl_tab [NCODE];
  logic [CW-1:0] up_tab  [NCODE];
  logic [CW-1:0] lo_tab  [NCODE];

  for (genvar g = 0; g < NCODE; g++) begin : g_tab
    assign lvl_tab[g] = CW'(trig_level(2'(g), DEPTH));
    assign up_tab[g]  = CW'(upper_level(2'(g), DEPTH));
    assign lo_tab[g]  = CW'(lower_level(2'(g), DEPTH));
  end

  logic [CW-1:0] cur_lvl, cur_up, cur_lo;

  always_comb begin
    cur_lvl = lvl_tab[trig_sel];
    cur_up  = up_tab[trig_sel];
    cur_lo  = lo_tab[trig_sel];
  end

  assign at_trig     = (fill >= cur_lvl);
  assign hit_upper   = (fill >= cur_up);
  // A zero lower level means reassert only once the FIFO is empty (R5).
  assign below_lower = (cur_lo == '0) ? (fill == '0) : (fill < cur_lo);

  // R2: the band is strictly ordered around the selected level.
  assert_band_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lo < cur_lvl) && (cur_lvl < cur_up));

  // R5 vs R4: the release and reassert conditions never both hold.
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_upper && below_lower));

endmodule

// File: rtl/rts_hyst_reg.sv
module rts_hyst_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic sw_rts,
  input  logic hit_upper,
  input  logic below_lower,
  output logic rts_n
);

  always_ff @(posedge clk) begin
    if (!rst_n)            rts_n <= 1'b1;
    else if (!auto_en)     rts_n <= ~sw_rts;
    else if (hit_upper)    rts_n <= 1'b1;
    else if (below_lower)  rts_n <= 1'b0;
  end

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && hit_upper) |=> rts_n);

  assert_reassert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && below_lower) |=> !rts_n);

  assert_hold_band_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !hit_upper && !below_lower) |=> $stable(rts_n));

  assert_sw_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> (rts_n == !$past(sw_rts)));

endmodule

// File: rtl/rts_irq_reg.sv
module rts_irq_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic at_trig,
  output logic thr_irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) thr_irq <= 1'b0;
    else        thr_irq <= at_trig;
  end

  assert_irq_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    at_trig |=> thr_irq);

  assert_irq_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !at_trig |=> !thr_irq);

endmodule

// File: rtl/rts_flow_ctrl.sv
module rts_flow_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] fill,
  input  logic [1:0]    trig_sel,
  input  logic          auto_en,
  input  logic          sw_rts,
  output logic          rts_n,
  output logic          thr_irq
);

  logic at_trig, hit_upper, below_lower;

  rts_level_decode #(.DEPTH(DEPTH)) u_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill        (fill),
    .trig_sel    (trig_sel),
    .at_trig     (at_trig),
    .hit_upper   (hit_upper),
    .below_lower (below_lower)
  );

  rts_hyst_reg u_hyst (
    .clk         (clk),
    .rst_n       (rst_n),
    .auto_en     (auto_en),
    .sw_rts      (sw_rts),
    .hit_upper   (hit_upper),
    .below_lower (below_lower),
    .rts_n       (rts_n)
  );

  rts_irq_reg u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .at_trig (at_trig),
    .thr_irq (thr_irq)
  );

  // R8: in automatic mode a software bit change alone never moves the line.
  assert_sw_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && $stable(fill) && $stable(trig_sel) && !hit_upper && !below_lower)
      |=> $stable(rts_n));

  // R4 (top-level view): a full FIFO always releases the line in automatic mode.
  assert_full_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && fill == CW'(DEPTH)) |=> rts_n);

endmodule

// File: tb/test_rts_flow_ctrl.sv
module test_rts_flow_ctrl;

  localparam int unsigned DEPTH = 16;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] fill = '0;
  logic [1:0]    trig_sel = 2'd0;
  logic          auto_en = 1'b0;
  logic          sw_rts = 1'b0;
  logic          rts_n, thr_irq;

  always #10 clk = ~clk;  // 50 MHz

  rts_flow_ctrl #(.DEPTH(DEPTH)) i_rts_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .fill(fill), .trig_sel(trig_sel),
    .auto_en(auto_en), .sw_rts(sw_rts), .rts_n(rts_n), .thr_irq(thr_irq)
  );

  typedef struct {
    int    due;
    logic  rts;
    logic  irq;
    string rtag;
    string itag;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic m_rts = 1'b1;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Independent restatement of the thresholds for DEPTH=16.
  function automatic int lvl16(input int s);
    case (s) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction
  function automatic int up16(input int s);
    case (s) 0: return 4; 1: return 8; 2: return 14; default: return 16; endcase
  endfunction
  function automatic int lo16(input int s);
    case (s) 0: return 0; 1: return 1; 2: return 4; default: return 8; endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic expv, input string what);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", tag, what, act, expv, cyc);
    end
  endtask

  task automatic step(input int f, input int s, input logic en, input logic sw,
                      input string rtag, input string itag);
    exp_t e;
    @(negedge clk);
    fill = CW'(f); trig_sel = 2'(s); auto_en = en; sw_rts = sw;
    if (!en)                  m_rts = ~sw;
    else if (f >= up16(s))    m_rts = 1'b1;
    else if (lo16(s) == 0 ? f == 0 : f < lo16(s)) m_rts = 1'b0;
    e.due = cyc + 1; e.rts = m_rts; e.irq = (f >= lvl16(s));
    e.rtag = rtag; e.itag = itag;
    exp_q.push_back(e);
  endtask

  // Monitor: pops every item whose result is due at this sampling point.
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.rtag, rts_n, e.rts, "rts_n");
      check(e.itag, thr_irq, e.irq, "thr_irq");
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs despite active inputs.
    fill = CW'(DEPTH); auto_en = 1'b1; sw_rts = 1'b1; trig_sel = 2'd0;
    repeat (3) @(negedge clk);
    check("R1", rts_n, 1'b1, "rts_n in reset");
    check("R1", thr_irq, 1'b0, "thr_irq in reset");
    @(negedge clk);
    rst_n = 1'b1; m_rts = 1'b1;

    // R2/R4/R5: ramp up and down for every code in automatic mode.
    for (int s = 0; s < 4; s++) begin
      for (int f = 0; f <= 16; f++) step(f, s, 1'b1, 1'b0, "R4", "R2");
      for (int f = 16; f >= 0; f--) step(f, s, 1'b1, 1'b0, "R5", "R2");
    end

    // R6: hold band for code 1 (level 4, release at 8, reassert below 1).
    step(0, 1, 1'b1, 1'b0, "R6", "R3");
    step(6, 1, 1'b1, 1'b0, "R6", "R3");
    step(8, 1, 1'b1, 1'b0, "R6", "R3");
    step(3, 1, 1'b1, 1'b0, "R6", "R3");
    step(1, 1, 1'b1, 1'b0, "R6", "R3");
    step(0, 1, 1'b1, 1'b0, "R6", "R3");

    // R7: software mode, fill ignored; R3: interrupt still tracks the level.
    step(16, 2, 1'b0, 1'b1, "R7", "R3");
    step(16, 2, 1'b0, 1'b0, "R7", "R3");
    step(0,  2, 1'b0, 1'b1, "R7", "R3");
    step(9,  2, 1'b0, 1'b0, "R7", "R3");
    step(9,  2, 1'b0, 1'b1, "R7", "R3");

    // R8: software bit ignored while pacing is on (code 2: release 14, reassert below 4).
    step(0,  2, 1'b1, 1'b0, "R8", "R3");
    step(6,  2, 1'b1, 1'b1, "R8", "R3");
    step(14, 2, 1'b1, 1'b1, "R8", "R3");
    step(10, 2, 1'b1, 1'b0, "R8", "R3");
    step(10, 2, 1'b1, 1'b1, "R8", "R3");

    // R9: code change inside the band takes effect on the next edge.
    step(0, 3, 1'b1, 1'b0, "R9", "R9");
    step(9, 3, 1'b1, 1'b0, "R9", "R9");
    step(9, 0, 1'b1, 1'b0, "R9", "R9");
    step(3, 3, 1'b1, 1'b0, "R9", "R9");
    step(3, 1, 1'b1, 1'b0, "R9", "R9");

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule